// File: doc/BRIEF.md
# HDLC Serial Frame Transmitter

This block turns a stream of tagged bytes into a bit-serial HDLC line signal. Each byte arrives over a valid/ready handshake with two tags: one marks the last byte of a packet, the other orders the packet to be abandoned. The block puts an opening flag in front of the first byte and sends data bits least significant first. It inserts a zero after every run of five ones inside the packet body and its check field. When the tagged last byte is done, it appends a 16-bit frame check sequence and a closing flag.

When nothing is queued, the line carries idle fill. A control input selects the fill: repeated flag octets, or a constant one level. A line-rate strobe advances the serial output by one bit, so the line can run at any fraction of the system clock. A separate enable stops the transmitter at once and parks the line at one. An abort, whether ordered by a tag or caused by the queue running dry inside a packet, replaces the rest of the packet with a zero followed by seven ones.

Top module: `hdlc_frame_tx`

## Requirements
- R1: With `fill_ones` low and no packet pending, the line repeats the flag octet 0x7E. A run of seven ones never appears.
- R2: With `fill_ones` high and no packet pending, every transmitted bit is one.
- R3: A packet is an opening flag, then its data bytes sent bit 0 first, then the check field, then a closing flag. A receiver that removes the inserted zeros recovers the bytes unchanged. No byte is accepted while the check field or a flag is being sent.
- R4: The check field is a CRC over the data bytes with the reflected polynomial x^16+x^12+x^5+1, preset to all ones. Its ones complement is sent low bit first. For the ASCII bytes "123456789", the two field bytes on the line are 0x6E and then 0x90.
- R5: Inside the data and check field, a zero follows every fifth consecutive one, so no run of six ones occurs there. Data made of all-ones bytes still decodes correctly.
- R6: A byte accepted with `in_abort` high is not sent. Instead the line carries a zero followed by seven ones, and the partial packet never forms a valid frame.
- R7: If no byte is offered when the next byte of an unfinished packet is due, the packet is aborted the same way as in R6.
- R8: While `tx_en` is low, `tx_bit` is one from the next clock on, and `in_ready` is low. After `tx_en` returns high, packets are sent normally.
- R9: In a cycle with `bit_en` low, `tx_bit` keeps its value and no byte is accepted.
- R10: During and right after reset, `tx_bit` is one and `in_ready` is low.
- R11: If a new packet is queued when a closing flag ends, the new packet's opening flag follows at once, with no idle fill between the two packets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_en | input | 1 | Transmitter enable; low forces the line to one |
| fill_ones | input | 1 | Idle fill select: 1 constant ones, 0 repeated flags |
| bit_en | input | 1 | Line-rate strobe; one serial bit per high cycle |
| in_data | input | DATA_W | Byte offered by the queue |
| in_eop | input | 1 | Tag: offered byte is the last of its packet |
| in_abort | input | 1 | Tag: abort the packet instead of sending this byte |
| in_valid | input | 1 | Queue has a byte to offer |
| in_ready | output | 1 | Byte is taken on this clock edge |
| tx_bit | output | 1 | Serial line output |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 16-bit check field with the reflected polynomial 0x8408, and a run length of five before a zero is inserted. With these values the frames on the line follow ordinary HDLC. A bench-side receiver removes the inserted zeros, finds flags and aborts, and compares the recovered bytes and check field with values the bench computes itself. The well-known "123456789" check value then pins down the CRC and bit order independently. All-ones and flag-valued data, line strobes at one third of the clock rate, and back-to-back packets in both fill modes bring the zero insertion, the hold behaviour and the flag sharing within reach.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  localparam int          FLAG_W   = 8;
  localparam logic [7:0]  FLAG_PAT = 8'h7E;

  typedef enum logic [2:0] {
    ST_FILL,
    ST_OPEN,
    ST_BODY,
    ST_CHECK,
    ST_CLOSE,
    ST_ABORT
  } tx_state_e;

endpackage

// File: rtl/hdlc_fcs_gen.sv
module hdlc_fcs_gen #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   POLY = 16'h8408
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic update,
  input  logic din,
  input  logic shift,
  output logic fcs_bit
);

  logic [W-1:0] crc_q, crc_d;
  logic         fb;

  assign fb = crc_q[0] ^ din;

  always_comb begin
    crc_d = crc_q;
    if (init) begin
      crc_d = '1;
    end else if (update) begin
      crc_d = {1'b0, crc_q[W-1:1]} ^ (fb ? POLY : '0);
    end else if (shift) begin
      crc_d = {1'b1, crc_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '1;
    else        crc_q <= crc_d;
  end

  assign fcs_bit = ~crc_q[0];

  // R4: the register is either folding in data or emitting the field, never both
  p_mode_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    update |-> !shift);

endmodule

// File: rtl/hdlc_zero_stuffer.sv
module hdlc_zero_stuffer #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  input  logic stuffable,
  input  logic bit_in,
  output logic stuff_now
);

  localparam int RC_W = $clog2(RUN_LEN + 1);

  logic [RC_W-1:0] run_q, run_d;

  assign stuff_now = (run_q == RC_W'(RUN_LEN));

  always_comb begin
    run_d = run_q;
    if (clear) begin
      run_d = '0;
    end else if (step) begin
      if (stuff_now)                run_d = '0;
      else if (stuffable && bit_in) run_d = run_q + 1'b1;
      else                          run_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  // R5: the ones counter never passes the insertion threshold
  p_run_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RC_W'(RUN_LEN));

endmodule

// File: rtl/hdlc_frame_tx.sv
module hdlc_frame_tx
  import hdlc_tx_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                FCS_W    = 16,
  parameter logic [FCS_W-1:0]  FCS_POLY = 16'h8408,
  parameter int                RUN_LEN  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              fill_ones,
  input  logic              bit_en,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_eop,
  input  logic              in_abort,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              tx_bit
);

  localparam int SPAN  = (FCS_W > DATA_W) ? FCS_W : DATA_W;
  localparam int CNT_W = $clog2(SPAN);
  localparam int DI_W  = $clog2(DATA_W);

  // asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign arst_n = rst_pipe[1];

  tx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic              eop_q, eop_d;
  logic              out_q, out_d;
  logic              bit_sel;
  logic              stuff_now;
  logic              fcs_bit;
  logic              step, adv;
  logic              last_flag, last_data, last_fcs;
  logic              take_slot;

  assign step      = bit_en && tx_en;
  assign adv       = step && !stuff_now;
  assign last_flag = (cnt_q == CNT_W'(FLAG_W - 1));
  assign last_data = (cnt_q == CNT_W'(DATA_W - 1));
  assign last_fcs  = (cnt_q == CNT_W'(FCS_W - 1));

  assign take_slot = ((state_q == ST_OPEN) && last_flag) ||
                     ((state_q == ST_BODY) && last_data && !eop_q);
  assign in_ready  = adv && take_slot;

  // next state and sequencing
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    byte_d  = byte_q;
    eop_d   = eop_q;
    if (!tx_en) begin
      state_d = ST_FILL;
      cnt_d   = '0;
    end else if (adv) begin
      cnt_d = cnt_q + 1'b1;
      unique case (state_q)
        ST_FILL: begin
          if (last_flag) begin
            cnt_d = '0;
            if (in_valid) state_d = ST_OPEN;
          end
        end
        ST_OPEN: begin
          if (last_flag) begin
            cnt_d = '0;
            if (in_valid && !in_abort) begin
              state_d = ST_BODY;
              byte_d  = in_data;
              eop_d   = in_eop;
            end else begin
              state_d = ST_ABORT;
            end
          end
        end
        ST_BODY: begin
          if (last_data) begin
            cnt_d = '0;
            if (eop_q) begin
              state_d = ST_CHECK;
            end else if (in_valid && !in_abort) begin
              byte_d = in_data;
              eop_d  = in_eop;
            end else begin
              state_d = ST_ABORT;
            end
          end
        end
        ST_CHECK: begin
          if (last_fcs) begin
            cnt_d   = '0;
            state_d = ST_CLOSE;
          end
        end
        ST_CLOSE, ST_ABORT: begin
          if (last_flag) begin
            cnt_d   = '0;
            state_d = in_valid ? ST_OPEN : ST_FILL;
          end
        end
        default: begin
          state_d = ST_FILL;
          cnt_d   = '0;
        end
      endcase
    end
  end

  // bit selection for the current slot
  always_comb begin
    bit_sel = 1'b1;
    unique case (state_q)
      ST_FILL:           bit_sel = fill_ones ? 1'b1 : FLAG_PAT[cnt_q[2:0]];
      ST_OPEN, ST_CLOSE: bit_sel = FLAG_PAT[cnt_q[2:0]];
      ST_BODY:           bit_sel = byte_q[cnt_q[DI_W-1:0]];
      ST_CHECK:          bit_sel = fcs_bit;
      ST_ABORT:          bit_sel = (cnt_q != '0);
      default:           bit_sel = 1'b1;
    endcase
    if (stuff_now) bit_sel = 1'b0;
  end

  always_comb begin
    out_d = out_q;
    if (!tx_en)    out_d = 1'b1;
    else if (step) out_d = bit_sel;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= ST_FILL;
      cnt_q   <= '0;
      byte_q  <= '0;
      eop_q   <= 1'b0;
      out_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      byte_q  <= byte_d;
      eop_q   <= eop_d;
      out_q   <= out_d;
    end
  end

  assign tx_bit = out_q;

  hdlc_fcs_gen #(
    .W    (FCS_W),
    .POLY (FCS_POLY)
  ) i_fcs (
    .clk     (clk),
    .rst_n   (arst_n),
    .init    (state_q == ST_OPEN),
    .update  (adv && (state_q == ST_BODY)),
    .din     (byte_q[cnt_q[DI_W-1:0]]),
    .shift   (adv && (state_q == ST_CHECK)),
    .fcs_bit (fcs_bit)
  );

  hdlc_zero_stuffer #(
    .RUN_LEN (RUN_LEN)
  ) i_stuff (
    .clk       (clk),
    .rst_n     (arst_n),
    .clear     (!tx_en),
    .step      (step),
    .stuffable ((state_q == ST_BODY) || (state_q == ST_CHECK)),
    .bit_in    (bit_sel),
    .stuff_now (stuff_now)
  );

  // R9: the line holds its bit while the strobe is low
  p_hold_r9: assert property (@(posedge clk) disable iff (!arst_n)
    (!bit_en && tx_en) |=> $stable(tx_bit));

  // R8: a disabled transmitter marks the line
  p_disabled_mark_r8: assert property (@(posedge clk) disable iff (!arst_n)
    !tx_en |=> tx_bit);

  // R5: a pending insertion puts a zero on the line
  p_stuff_zero_r5: assert property (@(posedge clk) disable iff (!arst_n)
    (stuff_now && step) |=> !tx_bit);

  // R3: nothing is taken while the check field goes out
  p_no_take_in_check_r3: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_CHECK) |-> !in_ready);

  // R6: after the leading zero, the abort pattern is all ones
  p_abort_ones_r6: assert property (@(posedge clk) disable iff (!arst_n)
    ((state_q == ST_ABORT) && adv && (cnt_q != '0)) |=> tx_bit);

endmodule

// File: tb/test_hdlc_frame_tx.sv
module test_hdlc_frame_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       fill_ones = 1'b0;
  logic       bit_en = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_eop = 1'b0;
  logic       in_abort = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       tx_bit;

  always #4 clk = ~clk;

  hdlc_frame_tx i_hdlc_frame_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .fill_ones (fill_ones),
    .bit_en    (bit_en),
    .in_data   (in_data),
    .in_eop    (in_eop),
    .in_abort  (in_abort),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .tx_bit    (tx_bit)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // byte source
  logic [7:0] src_mem [64];
  logic       src_eop [64];
  logic       src_abt [64];
  int src_len = 0;
  int src_idx = 0;
  int en_div  = 1;
  int ph      = 0;
  bit took    = 0;
  int rdy_err = 0;

  task automatic push(input logic [7:0] b, input logic e, input logic a);
    src_mem[src_len] = b;
    src_eop[src_len] = e;
    src_abt[src_len] = a;
    src_len++;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (took) src_idx++;
      bit_en = (en_div <= 1) ? 1'b1 : ((ph % en_div) == 0);
      ph++;
      in_valid = (src_idx < src_len);
      in_data  = in_valid ? src_mem[src_idx] : 8'h00;
      in_eop   = in_valid ? src_eop[src_idx] : 1'b0;
      in_abort = in_valid ? src_abt[src_idx] : 1'b0;
      #1;
      took = in_valid && in_ready;
      if (in_ready && !bit_en) rdy_err++;
    end
  end

  // line receiver
  logic en_q = 1'b0;
  always @(posedge clk) en_q <= bit_en;

  bit   fbits [1024];
  int   nbits = 0;
  int   ones = 0;
  bit   in_frame = 0;
  int   frame_cnt = 0, abort_cnt = 0, flag_cnt = 0, idle7_cnt = 0, zeros_seen = 0;
  int   rx_len = 0;
  bit   rx_bad = 0;
  logic [7:0] rx_bytes [32];
  bit   mon_hold = 0;
  int   hold_err = 0;
  logic last_bit = 1'b1;

  task automatic rx_take(input logic b);
    if (b) begin
      ones++;
      if (in_frame && nbits < 1023) begin fbits[nbits] = 1'b1; nbits++; end
      if (ones == 7) begin
        idle7_cnt++;
        if (in_frame && nbits >= 15) abort_cnt++;
        in_frame = 0;
      end
    end else begin
      zeros_seen++;
      if (ones == 5) begin
        // inserted zero, dropped
      end else if (ones == 6) begin
        flag_cnt++;
        if (in_frame && nbits > 7) begin
          rx_len = (nbits - 7) / 8;
          rx_bad = ((nbits - 7) % 8) != 0;
          for (int i = 0; i < 32; i++) begin
            rx_bytes[i] = 8'h00;
            if (i < rx_len)
              for (int k = 0; k < 8; k++) rx_bytes[i][k] = fbits[i*8+k];
          end
          frame_cnt++;
        end
        in_frame = 1;
        nbits = 0;
      end else if (in_frame && nbits < 1023) begin
        fbits[nbits] = 1'b0;
        nbits++;
      end
      ones = 0;
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && tx_en) begin
        if (en_q) rx_take(tx_bit);
        else if (mon_hold && tx_bit !== last_bit) hold_err++;
      end
      last_bit = tx_bit;
    end
  end

  function automatic logic [15:0] fcs_of(input int start, input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) begin
        logic fb = c[0] ^ src_mem[start+i][k];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    return ~c;
  endfunction

  task automatic wait_frames(input int target);
    for (int t = 0; t < 6000 && frame_cnt < target; t++) @(negedge clk);
  endtask

  task automatic check_frame(input int start, input int n, input string req);
    logic [15:0] f = fcs_of(start, n);
    bit same = 1;
    for (int i = 0; i < n; i++) if (rx_bytes[i] !== src_mem[start+i]) same = 0;
    chk(!rx_bad && rx_len == n + 2, req, "frame length", rx_len, n + 2);
    chk(same, req, "data bytes match", same, 1);
    chk(rx_bytes[n] == f[7:0] && rx_bytes[n+1] == f[15:8], "R4", "check field",
        {rx_bytes[n+1], rx_bytes[n]}, f);
  endtask

  // len[39:36], mark-idle mode [32], byte k at [8k+7:8k]
  localparam logic [39:0] VEC [6] = '{
    40'h10000000A5,
    40'h210000FFFF,
    40'h3000007E7E,
    40'h4104030201,
    40'h40F87FFEFF,
    40'h1100000000
  };

  int cycles = 0;
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int fc, snap, st, bad;
    repeat (4) @(negedge clk);
    chk(tx_bit === 1'b1, "R10", "line during reset", tx_bit, 1);
    chk(in_ready === 1'b0, "R10", "ready during reset", in_ready, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx_bit === 1'b1 && in_ready === 1'b0, "R10", "line after reset",
        {in_ready, tx_bit}, 1);

    // R8: disabled line
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tx_bit !== 1'b1 || in_ready !== 1'b0) bad++;
    end
    chk(bad == 0, "R8", "disabled cycles not marking", bad, 0);

    // R1: flag fill
    tx_en = 1'b1;
    fill_ones = 1'b0;
    repeat (24) @(negedge clk);
    snap = flag_cnt;
    st = idle7_cnt;
    repeat (80) @(negedge clk);
    chk(flag_cnt - snap >= 9, "R1", "flags seen in fill", flag_cnt - snap, 9);
    chk(idle7_cnt == st, "R1", "seven-ones runs in flag fill", idle7_cnt - st, 0);

    // R2: mark idle
    fill_ones = 1'b1;
    repeat (16) @(negedge clk);
    snap = zeros_seen;
    repeat (60) @(negedge clk);
    chk(zeros_seen == snap, "R2", "zeros in mark idle", zeros_seen - snap, 0);

    // vector table: R3, R4, R5
    for (int v = 0; v < 6; v++) begin
      int n = int'(VEC[v][39:36]);
      @(negedge clk);
      fill_ones = VEC[v][32];
      fc = frame_cnt;
      st = src_len;
      for (int k = 0; k < n; k++) push(VEC[v][8*k +: 8], k == n - 1, 1'b0);
      wait_frames(fc + 1);
      chk(frame_cnt == fc + 1, "R3", "frame received", frame_cnt - fc, 1);
      check_frame(st, n, (v == 1 || v == 4) ? "R5" : "R3");
    end

    // R4: known check value
    @(negedge clk);
    fill_ones = 1'b0;
    fc = frame_cnt;
    st = src_len;
    for (int k = 0; k < 9; k++) push(8'h31 + 8'(k), k == 8, 1'b0);
    wait_frames(fc + 1);
    chk(rx_len == 11 && rx_bytes[9] == 8'h6E && rx_bytes[10] == 8'h90, "R4",
        "123456789 field", {rx_bytes[10], rx_bytes[9]}, 16'h906E);

    // R6: abort tag
    @(negedge clk);
    fc = frame_cnt;
    snap = abort_cnt;
    push(8'hA1, 1'b0, 1'b0);
    push(8'hB2, 1'b0, 1'b0);
    push(8'hC3, 1'b0, 1'b1);
    for (int t = 0; t < 2000 && src_idx < src_len; t++) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(abort_cnt == snap + 1, "R6", "abort seen", abort_cnt - snap, 1);
    chk(frame_cnt == fc, "R6", "no frame from aborted packet", frame_cnt - fc, 0);
    st = src_len;
    push(8'h5A, 1'b1, 1'b0);
    wait_frames(fc + 1);
    check_frame(st, 1, "R6");

    // R7: underrun
    @(negedge clk);
    fc = frame_cnt;
    snap = abort_cnt;
    push(8'h11, 1'b0, 1'b0);
    push(8'h22, 1'b0, 1'b0);
    for (int t = 0; t < 2000 && src_idx < src_len; t++) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(abort_cnt == snap + 1, "R7", "underrun abort", abort_cnt - snap, 1);
    chk(frame_cnt == fc, "R7", "no frame on underrun", frame_cnt - fc, 0);

    // R11: back-to-back in mark idle
    fill_ones = 1'b1;
    repeat (30) @(negedge clk);
    fc = frame_cnt;
    snap = idle7_cnt;
    st = src_len;
    push(8'h81, 1'b0, 1'b0);
    push(8'h42, 1'b1, 1'b0);
    push(8'hE7, 1'b1, 1'b0);
    wait_frames(fc + 2);
    chk(frame_cnt == fc + 2, "R11", "two frames", frame_cnt - fc, 2);
    chk(idle7_cnt == snap, "R11", "idle between packets", idle7_cnt - snap, 0);
    check_frame(st + 2, 1, "R11");

    // R9: slow strobe
    en_div = 3;
    mon_hold = 1;
    rdy_err = 0;
    @(negedge clk);
    fc = frame_cnt;
    st = src_len;
    push(8'h3C, 1'b0, 1'b0);
    push(8'hFF, 1'b1, 1'b0);
    wait_frames(fc + 1);
    repeat (10) @(negedge clk);
    mon_hold = 0;
    check_frame(st, 2, "R9");
    chk(hold_err == 0, "R9", "bit changed with strobe low", hold_err, 0);
    chk(rdy_err == 0, "R9", "ready with strobe low", rdy_err, 0);
    en_div = 1;

    // R8: disable mid-packet, then recover
    @(negedge clk);
    push(8'h10, 1'b0, 1'b0);
    push(8'h20, 1'b0, 1'b0);
    push(8'h30, 1'b0, 1'b0);
    push(8'h40, 1'b1, 1'b0);
    repeat (20) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      if (tx_bit !== 1'b1 || in_ready !== 1'b0) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R8", "line while disabled mid-packet", bad, 0);
    tx_en = 1'b1;
    fc = frame_cnt;
    wait_frames(fc + 1);
    chk(frame_cnt == fc + 1 && !rx_bad, "R8", "frame after re-enable",
        frame_cnt - fc, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule